// File: doc/BRIEF.md
# Boundary Scan Test Access Port with Probe and User Registers

This block is a boundary scan test access port controller. It runs on the test clock. The sixteen-state controller follows the mode-select line, which is sampled on each rising edge. A 3-bit instruction chooses which data register sits between the serial input and the serial output. The choices are:

- a one-bit bypass stage;
- a parameterised boundary register with an update stage;
- a private probe register that captures internal debug nodes;
- a user data register that gives application access, for example memory reads and writes.

There is no dedicated test reset pin. A power-on reset, active low and synchronous to the test clock, puts the controller into Test-Logic-Reset and loads BYPASS.

The block also steers the pin-side boundary controls. It decides whether pins are driven from the core or from the boundary update stage, and whether output enables are forced off. It decides whether core inputs see the pins or the boundary update stage. It gives a one-hot decode of the active instruction. The pin cells themselves and the probe hardware lie outside the block.

Top module: `scan_tap_top`

## Requirements
- R1: The controller has the standard sixteen states and advances on the rising edge of `tck` by `tms`. Five rising edges with `tms` high reach Test-Logic-Reset from any state, and that state loads BYPASS (3'b111) as the active instruction.
- R2: While `por_n` is low at a rising edge of `tck`, the controller enters Test-Logic-Reset and the active instruction becomes 3'b111. While `por_n` is low at a falling edge, `tdo_oe` is driven low.
- R3: The instruction shift stage is 3 bits. It loads 3'b001 in Capture-IR and shifts least significant bit first, with `tdi` entering at the top bit. It becomes active in Update-IR. The codes are 000 external test, 001 sample/preload, 010 internal test, 011 probe, 100 user, 101 high-Z, 110 clamp and 111 bypass.
- R4: `instr_dec` is one-hot, with bit k high when the active instruction code equals k.
- R5: The scan path length and source depend on the instruction, as follows:
  - codes 101, 110 and 111 use the 1-bit bypass stage, which captures 0;
  - codes 000, 001 and 010 use the BSR_W-bit boundary register;
  - code 011 uses the PROBE_W-bit probe register;
  - code 100 uses the USER_W-bit user register.
- R6: In Capture-DR, the boundary register loads `core_out` under code 010 and `pin_in` under codes 000 and 001. It copies its shift contents into the update stage in Update-DR under those codes only.
- R7: Under codes 000 and 110, `pin_out` equals the boundary update stage and `pin_oe` is 1. Under code 101, `pin_oe` is 0 and `pin_out` equals `core_out`. Under all other codes, `pin_out` equals `core_out` and `pin_oe` equals `core_oe`.
- R8: `core_in` equals the boundary update stage under code 010 and `pin_in` otherwise.
- R9: Under code 011, Capture-DR loads `probe_in` into the probe register.
- R10: Under code 100, Capture-DR loads `user_rd_data`. Update-DR copies the shifted contents to `user_wr_data` and raises `user_upd` for exactly one `tck` cycle.
- R11: `tdo` changes only on the falling edge of `tck`, presenting the least significant bit of the selected register first. `tdo_oe` is high only after a falling edge in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, synchronous to tck |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Enable for tdo, high while shifting |
| pin_in | input | BSR_W | Values seen at the pins |
| core_out | input | BSR_W | Values the core wants on the pins |
| core_oe | input | 1 | Output enable requested by the core |
| pin_out | output | BSR_W | Values sent to the pin drivers |
| pin_oe | output | 1 | Output enable sent to the pin drivers |
| core_in | output | BSR_W | Values presented to the core inputs |
| probe_in | input | PROBE_W | Internal debug nodes for the probe register |
| user_rd_data | input | USER_W | Data captured by the user register |
| user_wr_data | output | USER_W | Data written out by the user register |
| user_upd | output | 1 | One-cycle pulse after a user update |
| instr_dec | output | 8 | One-hot decode of the active instruction |

## Verification
A wrong controller state shows up one edge later as a misplaced `tdo_oe` window or as a scan of the wrong length. The bench measures the length for every instruction by shifting a single one through zeroed capture data. A wrong instruction register shows up at once on `instr_dec`, on the pin steering and on the chosen scan length. A fault in the capture or update paths appears after one scan, as shifted-out data that differs from the captured inputs or as pin and core values that differ from the preloaded pattern. A spurious or missing `user_upd` pulse is counted across the user write.

// File: rtl/scan_tap_pkg.sv
// Shared types for the scan test access port.
// Assumes a 3-bit instruction code and four data register groups.
package scan_tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_t;

    localparam int IR_W  = 3;
    localparam int OP_NUM = 1 << IR_W;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'd0;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'd1;
    localparam logic [IR_W-1:0] OP_INTEST = 3'd2;
    localparam logic [IR_W-1:0] OP_PROBE  = 3'd3;
    localparam logic [IR_W-1:0] OP_USER   = 3'd4;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 3'd5;
    localparam logic [IR_W-1:0] OP_CLAMP  = 3'd6;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'd7;
    localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

    typedef enum logic [1:0] {DRS_BYPASS, DRS_BOUND, DRS_PROBE, DRS_USER} dr_sel_t;

    // Map an instruction code to the data register group it places in the path.
    function automatic dr_sel_t dr_select(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLE, OP_INTEST: dr_select = DRS_BOUND;
            OP_PROBE:                        dr_select = DRS_PROBE;
            OP_USER:                         dr_select = DRS_USER;
            default:                         dr_select = DRS_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test access port controller.
// Advances on rising tck according to tms; a low por_n forces Test-Logic-Reset.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state table of the controller.
    always_comb begin
        case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    // State register with synchronous power-on reset.
    always_ff @(posedge tck) begin
        if (!por_n) state <= TS_RESET;
        else        state <= nxt;
    end

    // R1
    tlr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_RESET && tms) |=> (state == TS_RESET));

    // R1
    shift_dr_stay_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_SH_DR && !tms) |=> (state == TS_SH_DR));

endmodule

// File: rtl/scan_tap_ir.sv
// Instruction shift stage, active instruction and one-hot decode.
// Assumes the state comes from scan_tap_fsm on the same tck.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic              tck,
    input  logic              por_n,
    input  logic              tdi,
    input  tap_state_t        state,
    output logic [IR_W-1:0]   ir_cur,
    output logic              ir_lsb,
    output logic [OP_NUM-1:0] instr_dec
);

    logic [IR_W-1:0] ir_sr;

    // Instruction shift stage: capture the fixed pattern, shift LSB first.
    always_ff @(posedge tck) begin
        if (!por_n)                  ir_sr <= IR_CAPTURE_PAT;
        else if (state == TS_CAP_IR) ir_sr <= IR_CAPTURE_PAT;
        else if (state == TS_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Active instruction: bypass after reset, loaded in Update-IR.
    always_ff @(posedge tck) begin
        if (!por_n || state == TS_RESET) ir_cur <= OP_BYPASS;
        else if (state == TS_UPD_IR)     ir_cur <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

    for (genvar g = 0; g < OP_NUM; g++) begin : g_dec
        assign instr_dec[g] = (ir_cur == IR_W'(g));
    end

    // R3
    ir_capture_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_CAP_IR) |=> (ir_sr == IR_CAPTURE_PAT));

    // R1
    ir_tlr_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state == TS_RESET) |=> (ir_cur == OP_BYPASS));

    // R3
    ir_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_cur));

    // R4
    dec_onehot_chk: assert property (@(posedge tck) disable iff (!por_n)
        $onehot(instr_dec));

endmodule

// File: rtl/scan_tap_shreg.sv
// Generic capture/shift register of width W, shifted toward bit 0.
// Assumes the enables are mutually exclusive; W may be 1.
module scan_tap_shreg #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         por_n,
    input  logic         cap_en,
    input  logic         sh_en,
    input  logic         sdi,
    input  logic [W-1:0] cap_val,
    output logic [W-1:0] q
);

    logic [W-1:0] shifted;

    if (W == 1) begin : g_one
        assign shifted = sdi;
    end else begin : g_many
        assign shifted = {sdi, q[W-1:1]};
    end

    // Capture parallel data or shift one place per enabled edge.
    always_ff @(posedge tck) begin
        if (!por_n)      q <= '0;
        else if (cap_en) q <= cap_val;
        else if (sh_en)  q <= shifted;
    end

endmodule

// File: rtl/scan_tap_dr.sv
// Data register bank: bypass, boundary with update stage, probe, and user.
// Assumes the active instruction is stable through a data register scan.
module scan_tap_dr
    import scan_tap_pkg::*;
#(
    parameter int BSR_W   = 8,
    parameter int PROBE_W = 6,
    parameter int USER_W  = 10
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              tdi,
    input  tap_state_t        state,
    input  logic [IR_W-1:0]   ir_cur,
    input  logic [BSR_W-1:0]  pin_in,
    input  logic [BSR_W-1:0]  core_out,
    input  logic [PROBE_W-1:0] probe_in,
    input  logic [USER_W-1:0] user_rd_data,
    output logic              dr_lsb,
    output logic [BSR_W-1:0]  bsr_upd,
    output logic [USER_W-1:0] user_wr_data,
    output logic              user_upd
);

    dr_sel_t            sel;
    logic               cap, sh, upd;
    logic               byp_q;
    logic [BSR_W-1:0]   bsr_q, bsr_cap;
    logic [PROBE_W-1:0] prb_q;
    logic [USER_W-1:0]  usr_q;

    assign sel     = dr_select(ir_cur);
    assign cap     = (state == TS_CAP_DR);
    assign sh      = (state == TS_SH_DR);
    assign upd     = (state == TS_UPD_DR);
    assign bsr_cap = (ir_cur == OP_INTEST) ? core_out : pin_in;

    // One-bit bypass stage: captures zero, then follows tdi.
    always_ff @(posedge tck) begin
        if (!por_n)                           byp_q <= 1'b0;
        else if (cap && sel == DRS_BYPASS)    byp_q <= 1'b0;
        else if (sh && sel == DRS_BYPASS)     byp_q <= tdi;
    end

    scan_tap_shreg #(.W(BSR_W)) bsr_i (
        .tck(tck), .por_n(por_n),
        .cap_en(cap && sel == DRS_BOUND), .sh_en(sh && sel == DRS_BOUND),
        .sdi(tdi), .cap_val(bsr_cap), .q(bsr_q));

    scan_tap_shreg #(.W(PROBE_W)) prb_i (
        .tck(tck), .por_n(por_n),
        .cap_en(cap && sel == DRS_PROBE), .sh_en(sh && sel == DRS_PROBE),
        .sdi(tdi), .cap_val(probe_in), .q(prb_q));

    scan_tap_shreg #(.W(USER_W)) usr_i (
        .tck(tck), .por_n(por_n),
        .cap_en(cap && sel == DRS_USER), .sh_en(sh && sel == DRS_USER),
        .sdi(tdi), .cap_val(user_rd_data), .q(usr_q));

    // Boundary update stage: holds the pattern the pin and core steering use.
    always_ff @(posedge tck) begin
        if (!por_n)                       bsr_upd <= '0;
        else if (upd && sel == DRS_BOUND) bsr_upd <= bsr_q;
    end

    // User write-out register and its one-cycle strobe.
    always_ff @(posedge tck) begin
        if (!por_n) begin
            user_wr_data <= '0;
            user_upd     <= 1'b0;
        end else begin
            user_upd <= upd && sel == DRS_USER;
            if (upd && sel == DRS_USER) user_wr_data <= usr_q;
        end
    end

    // Serial output source for the selected group.
    always_comb begin
        case (sel)
            DRS_BOUND: dr_lsb = bsr_q[0];
            DRS_PROBE: dr_lsb = prb_q[0];
            DRS_USER:  dr_lsb = usr_q[0];
            default:   dr_lsb = byp_q;
        endcase
    end

    // R10
    user_pulse_chk: assert property (@(posedge tck) disable iff (!por_n)
        user_upd |=> !user_upd);

    // R6
    bsr_hold_chk: assert property (@(posedge tck) disable iff (!por_n)
        (!upd) |=> $stable(bsr_upd));

    // R5
    bypass_cap_chk: assert property (@(posedge tck) disable iff (!por_n)
        (cap && sel == DRS_BYPASS) |=> (byp_q == 1'b0));

endmodule

// File: rtl/scan_tap_top.sv
// Test access port top: controller, instruction and data registers,
// falling-edge serial output, and boundary pin/core steering.
// Assumes por_n is held low for at least one rising and one falling tck edge.
module scan_tap_top
    import scan_tap_pkg::*;
#(
    parameter int BSR_W   = 8,
    parameter int PROBE_W = 6,
    parameter int USER_W  = 10
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_oe,
    input  logic [BSR_W-1:0]   pin_in,
    input  logic [BSR_W-1:0]   core_out,
    input  logic               core_oe,
    output logic [BSR_W-1:0]   pin_out,
    output logic               pin_oe,
    output logic [BSR_W-1:0]   core_in,
    input  logic [PROBE_W-1:0] probe_in,
    input  logic [USER_W-1:0]  user_rd_data,
    output logic [USER_W-1:0]  user_wr_data,
    output logic               user_upd,
    output logic [7:0]         instr_dec
);

    tap_state_t       state;
    logic [IR_W-1:0]  ir_cur;
    logic             ir_lsb, dr_lsb, ext_drive;
    logic [BSR_W-1:0] bsr_upd;

    scan_tap_fsm fsm_i (.tck(tck), .por_n(por_n), .tms(tms), .state(state));

    scan_tap_ir ir_i (
        .tck(tck), .por_n(por_n), .tdi(tdi), .state(state),
        .ir_cur(ir_cur), .ir_lsb(ir_lsb), .instr_dec(instr_dec));

    scan_tap_dr #(.BSR_W(BSR_W), .PROBE_W(PROBE_W), .USER_W(USER_W)) dr_i (
        .tck(tck), .por_n(por_n), .tdi(tdi), .state(state), .ir_cur(ir_cur),
        .pin_in(pin_in), .core_out(core_out), .probe_in(probe_in),
        .user_rd_data(user_rd_data), .dr_lsb(dr_lsb), .bsr_upd(bsr_upd),
        .user_wr_data(user_wr_data), .user_upd(user_upd));

    // Serial output stage, updated half a cycle after the shift edge.
    always_ff @(negedge tck) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == TS_SH_IR) begin
            tdo    <= ir_lsb;
            tdo_oe <= 1'b1;
        end else if (state == TS_SH_DR) begin
            tdo    <= dr_lsb;
            tdo_oe <= 1'b1;
        end else begin
            tdo_oe <= 1'b0;
        end
    end

    // Pin and core steering from the active instruction.
    assign ext_drive = (ir_cur == OP_EXTEST) || (ir_cur == OP_CLAMP);
    assign pin_out   = ext_drive ? bsr_upd : core_out;
    assign pin_oe    = (ir_cur == OP_HIGHZ) ? 1'b0 : (ext_drive ? 1'b1 : core_oe);
    assign core_in   = (ir_cur == OP_INTEST) ? bsr_upd : pin_in;

    // R11
    tdo_oe_window_chk: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == TS_SH_IR || state == TS_SH_DR));

    // R11
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!por_n)
        (!tdo_oe) |=> $stable(tdo) || tdo_oe);

    // R7
    highz_chk: assert property (@(posedge tck) disable iff (!por_n)
        instr_dec[OP_HIGHZ] |-> !pin_oe);

endmodule

// File: tb/scan_tap_top_tb_top.sv
// Self-checking bench for scan_tap_top.
module scan_tap_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BW = 8, PW = 6, UW = 10;

    logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, pin_oe, core_oe = 1'b0, user_upd;
    logic [BW-1:0] pin_in = '0, core_out = '0, pin_out, core_in;
    logic [PW-1:0] probe_in = '0;
    logic [UW-1:0] user_rd_data = '0, user_wr_data;
    logic [7:0] instr_dec;

    int n_chk = 0, n_fail = 0, upd_cnt = 0;
    logic oe_seen;
    logic [63:0] dout;
    logic [2:0] irout;

    // Table: {op[2:0], scan length[4:0], pad[6:0], pin_oe with core_oe=0}
    localparam logic [15:0] VEC [0:7] = '{
        {3'd0, 5'd8,  7'd0, 1'b1},
        {3'd1, 5'd8,  7'd0, 1'b0},
        {3'd2, 5'd8,  7'd0, 1'b0},
        {3'd3, 5'd6,  7'd0, 1'b0},
        {3'd4, 5'd10, 7'd0, 1'b0},
        {3'd5, 5'd1,  7'd0, 1'b0},
        {3'd6, 5'd1,  7'd0, 1'b1},
        {3'd7, 5'd1,  7'd0, 1'b0}
    };

    scan_tap_top #(.BSR_W(BW), .PROBE_W(PW), .USER_W(UW)) dut_i (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe), .pin_out(pin_out),
        .pin_oe(pin_oe), .core_in(core_in), .probe_in(probe_in),
        .user_rd_data(user_rd_data), .user_wr_data(user_wr_data),
        .user_upd(user_upd), .instr_dec(instr_dec));

    always #(CLK_PERIOD/2) tck = ~tck;

    always @(negedge tck) if (por_n && user_upd) upd_cnt++;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        @(negedge tck); #1;
        tms = m; tdi = d;
        @(posedge tck);
    endtask

    task automatic settle();
        @(negedge tck); #1;
    endtask

    // From Run-Test/Idle: load an opcode, return the captured IR bits.
    task automatic load_ir(input logic [2:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge tck); #1;
            irout[i] = tdo;
            tms = (i == 2); tdi = op[i];
            @(posedge tck);
        end
        step(1, 0); step(0, 0);
        settle();
    endtask

    // From Run-Test/Idle: scan n bits of din, collect tdo into dout.
    task automatic scan_dr(input logic [63:0] din, input int n);
        dout = '0; oe_seen = 1'b1;
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge tck); #1;
            dout[i] = tdo;
            oe_seen = oe_seen & tdo_oe;
            tms = (i == n - 1); tdi = din[i];
            @(posedge tck);
        end
        step(1, 0); step(0, 0);
        settle();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        int len;
        repeat (3) @(posedge tck);
        settle();
        // R2: reset state
        chk(instr_dec == 8'h80, "R2 reset instr", instr_dec, 8'h80);
        chk(tdo_oe == 1'b0, "R2 reset tdo_oe", tdo_oe, 0);
        por_n = 1'b1;
        step(0, 0);  // to Run-Test/Idle

        // Table walk: decode, scan length, output enable (R4, R5, R7)
        for (int v = 0; v < 8; v++) begin
            load_ir(VEC[v][15:13]);
            chk(irout == 3'b001, "R3 IR capture", irout, 3'b001);
            chk(instr_dec == (8'h1 << VEC[v][15:13]), "R4 decode", instr_dec, 8'h1 << VEC[v][15:13]);
            chk(pin_oe == VEC[v][0], "R7 pin_oe", pin_oe, VEC[v][0]);
            scan_dr(64'h1, 32);
            len = 99;
            for (int k = 31; k >= 0; k--) if (dout[k]) len = k;
            chk(len == int'(VEC[v][12:8]), "R5 scan length", len, VEC[v][12:8]);
            chk(oe_seen, "R11 tdo_oe while shifting", oe_seen, 1);
            chk(tdo_oe == 1'b0, "R11 tdo_oe idle", tdo_oe, 0);
        end

        // R6 / R7: sample capture and preload, then drive under external test and clamp
        pin_in = 8'hA5; core_out = 8'hC3; core_oe = 1'b1;
        load_ir(3'd1);
        scan_dr(64'h5A, 8);
        chk(dout[7:0] == 8'hA5, "R6 sample capture", dout[7:0], 8'hA5);
        chk(pin_out == 8'hC3, "R7 sample passes core", pin_out, 8'hC3);
        load_ir(3'd0);
        chk(pin_out == 8'h5A, "R7 extest drives preload", pin_out, 8'h5A);
        load_ir(3'd6);
        chk(pin_out == 8'h5A && pin_oe, "R7 clamp drive", {pin_oe, pin_out}, 9'h15A);
        load_ir(3'd5);
        chk(!pin_oe && pin_out == 8'hC3, "R7 highz", {pin_oe, pin_out}, 9'h0C3);

        // R8 / R6: internal test captures core outputs and feeds core inputs
        core_out = 8'h3C;
        load_ir(3'd2);
        scan_dr(64'h96, 8);
        chk(dout[7:0] == 8'h3C, "R6 intest capture", dout[7:0], 8'h3C);
        chk(core_in == 8'h96, "R8 intest core_in", core_in, 8'h96);
        load_ir(3'd7);
        chk(core_in == 8'hA5, "R8 normal core_in", core_in, 8'hA5);

        // R9: probe capture
        probe_in = 6'h2D;
        load_ir(3'd3);
        scan_dr(64'h0, 6);
        chk(dout[5:0] == 6'h2D, "R9 probe capture", dout[5:0], 6'h2D);

        // R10: user register read, write and strobe
        user_rd_data = 10'h3C1;
        load_ir(3'd4);
        upd_cnt = 0;
        scan_dr(64'h155, 10);
        settle();
        chk(dout[9:0] == 10'h3C1, "R10 user capture", dout[9:0], 10'h3C1);
        chk(user_wr_data == 10'h155, "R10 user write", user_wr_data, 10'h155);
        chk(upd_cnt == 1, "R10 user strobe count", upd_cnt, 1);

        // R1: five TMS-high edges return to reset and load bypass
        load_ir(3'd4);
        for (int i = 0; i < 5; i++) step(1, 0);
        settle();
        chk(instr_dec == 8'h80, "R1 tms reset", instr_dec, 8'h80);
        step(0, 0);

        // R2: power-on reset in the middle of a shift
        load_ir(3'd3);
        step(1, 0); step(0, 0); step(0, 0);
        @(negedge tck); #1;
        por_n = 1'b0; tms = 1'b0;
        @(negedge tck); #1;
        chk(tdo_oe == 1'b0, "R2 por tdo_oe", tdo_oe, 0);
        chk(instr_dec == 8'h80, "R2 por instr", instr_dec, 8'h80);
        por_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule